// File: doc/BRIEF.md
# Per-core down-counting interval timer

This block is a private timer for one processor core. Software reaches it over a small word-indexed register bus. It holds four registers: a reload value, a live down counter, a control word and a sticky event flag. While enabled, the counter drops by one on each prescaled tick. When it reaches zero, the event flag is set. The counter then either reloads and keeps going, or parks at zero.

The interrupt line is the event flag masked by an enable bit in the control word. A control write does one of three things to the running countdown. If the timer is already counting down from a nonzero value, the write leaves the countdown alone. If the enable bit is written as zero, the countdown halts on the spot. Otherwise the write arms a fresh countdown, reloading the counter first when auto-reload is requested. The tick input is a free-running enable from the surrounding clock tree, and an 8-bit prescale field in the control word divides it.

Top module: `cpu_private_timer`

## Requirements
- R1: After reset all four registers read zero and `irq` is low.
- R2: The word index selects the register: 0 is reload (a write also copies the value into the counter), 1 is the counter (read and write), 2 is control and 3 is the event status. In control, bit 0 enables counting, bit 1 selects auto-reload, bit 2 unmasks the interrupt and bits 15:8 hold the prescale value; every other control bit reads zero.
- R3: While enabled with a nonzero count, the counter falls by exactly one on each prescaled tick.
- R4: The step that takes the counter from 1 to 0 sets the event flag (status bit 0). Without auto-reload the counter then stays at zero.
- R5: With auto-reload, the step that would reach zero sets the event flag and loads the reload value in the same cycle, and counting continues.
- R6: `irq` is high exactly when the event flag is set and control bit 2 is set. With bit 2 clear the flag still reads back as set.
- R7: Writing status with bit 0 set clears the event flag. Writing it with bit 0 clear changes nothing.
- R8: A control write with bit 0 set, made while the timer is enabled and the count is nonzero, does not disturb the countdown, including a tick that falls in that cycle.
- R9: Any other control write with bit 0 set arms the countdown: with bit 1 set the counter is loaded from reload, otherwise it keeps its value. No step occurs in the arming cycle.
- R10: A control write with bit 0 clear halts the counter at once. No step occurs in that cycle, and the value is held afterwards.
- R11: With prescale value p, the first step comes p+1 ticks after arming, and later steps come every p+1 ticks.
- R12: While `tick_en` is low the counter and the prescaler do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer tick enable, one pulse per base tick |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | High for a write, low for a read |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for the addressed register (combinational) |
| irq | output | 1 | Masked timer interrupt |

## Verification
The hardest case to reach is a control write that re-enables the timer while it is already enabled but parked at zero after a one-shot expiry. This must count as a fresh arm and reload the counter, unlike the same write made while a countdown is still live. The bench runs a one-shot countdown to zero, keeps the enable bit set, and then writes control with auto-reload. It compares that result against an identical write made in the middle of a running countdown, where the tick in the write cycle must still land. A halt write is timed so that a tick coincides with it, which shows that no step slips through.

// File: rtl/timer_pkg.sv
package timer_pkg;
   typedef enum logic [1:0] {
      RIX_RELOAD = 2'd0,
      RIX_COUNT  = 2'd1,
      RIX_CTRL   = 2'd2,
      RIX_STATUS = 2'd3
   } reg_idx_e;

   localparam int CB_RUN    = 0;
   localparam int CB_AUTO   = 1;
   localparam int CB_UNMASK = 2;
   localparam int CB_DIV    = 8;
endpackage

// File: rtl/timer_prescale.sv
module timer_prescale #(
   parameter int PRESC_W = 8,
   localparam int PW = (PRESC_W > 0) ? PRESC_W : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic          run,
   input  logic          restart,
   input  logic          stop,
   input  logic [PW-1:0] divide,
   output logic          step
);
   generate
      if (PRESC_W > 0) begin : g_div
         logic [PW-1:0] phase_q;
         logic          wrap;

         assign wrap = (phase_q >= divide);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (!run || restart || stop) begin
               phase_q <= '0;
            end else if (tick_en) begin
               if (wrap) phase_q <= '0;
               else      phase_q <= phase_q + 1'b1;
            end
         end

         assign step = run && tick_en && !restart && !stop && wrap;
      end else begin : g_nodiv
         logic unused_div;
         assign unused_div = ^divide;
         assign step = run && tick_en && !restart && !stop;
      end
   endgenerate
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set,
   input  logic [DW-1:0] set_val,
   input  logic          arm_reload,
   input  logic [DW-1:0] reload_val,
   input  logic          auto_rl,
   input  logic          step,
   output logic [DW-1:0] count,
   output logic          hit_zero
);
   logic [DW-1:0] cnt_q;
   logic          last;

   assign last     = (cnt_q == DW'(1));
   assign hit_zero = step && last && !set;
   assign count    = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (set) begin
         cnt_q <= set_val;
      end else if (arm_reload) begin
         cnt_q <= reload_val;
      end else if (step) begin
         if (last)              cnt_q <= auto_rl ? reload_val : '0;
         else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
         else if (auto_rl)      cnt_q <= reload_val;
      end
   end
endmodule

// File: rtl/timer_regs.sv
module timer_regs
   import timer_pkg::*;
#(
   parameter int DW = 32,
   parameter int PRESC_W = 8,
   localparam int PW = (PRESC_W > 0) ? PRESC_W : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_sel,
   input  logic          bus_wr,
   input  logic [1:0]    bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic [DW-1:0] count,
   input  logic          hit_zero,
   output logic [DW-1:0] reload_q,
   output logic          run_q,
   output logic          auto_q,
   output logic          unmask_q,
   output logic [PW-1:0] divide_q,
   output logic          flag_q,
   output logic          cnt_set,
   output logic [DW-1:0] cnt_set_val,
   output logic          arm,
   output logic          arm_reload,
   output logic          halt
);
   logic     wr;
   reg_idx_e idx;
   logic     wr_ctrl;
   logic     live;

   assign idx     = reg_idx_e'(bus_addr);
   assign wr      = bus_sel && bus_wr;
   assign wr_ctrl = wr && (idx == RIX_CTRL);
   assign live    = run_q && (count != '0);

   assign arm        = wr_ctrl && bus_wdata[CB_RUN] && !live;
   assign arm_reload = arm && bus_wdata[CB_AUTO];
   assign halt       = wr_ctrl && !bus_wdata[CB_RUN];

   assign cnt_set     = wr && ((idx == RIX_RELOAD) || (idx == RIX_COUNT));
   assign cnt_set_val = bus_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '0;
         run_q    <= 1'b0;
         auto_q   <= 1'b0;
         unmask_q <= 1'b0;
         flag_q   <= 1'b0;
      end else begin
         if (wr && idx == RIX_RELOAD) reload_q <= bus_wdata;
         if (wr_ctrl) begin
            run_q    <= bus_wdata[CB_RUN];
            auto_q   <= bus_wdata[CB_AUTO];
            unmask_q <= bus_wdata[CB_UNMASK];
         end
         if (hit_zero)
            flag_q <= 1'b1;
         else if (wr && idx == RIX_STATUS && bus_wdata[0])
            flag_q <= 1'b0;
      end
   end

   generate
      if (PRESC_W > 0) begin : g_div_reg
         always_ff @(posedge clk) begin
            if (!rst_n)       divide_q <= '0;
            else if (wr_ctrl) divide_q <= bus_wdata[CB_DIV +: PRESC_W];
         end
      end else begin : g_no_div_reg
         assign divide_q = '0;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      unique case (idx)
         RIX_RELOAD: bus_rdata = reload_q;
         RIX_COUNT:  bus_rdata = count;
         RIX_CTRL: begin
            bus_rdata[CB_RUN]    = run_q;
            bus_rdata[CB_AUTO]   = auto_q;
            bus_rdata[CB_UNMASK] = unmask_q;
            if (PRESC_W > 0) bus_rdata[CB_DIV +: PW] = divide_q;
         end
         RIX_STATUS: bus_rdata[0] = flag_q;
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/cpu_private_timer.sv
module cpu_private_timer #(
   parameter int DW = 32,
   parameter int PRESC_W = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic          bus_sel,
   input  logic          bus_wr,
   input  logic [1:0]    bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          irq
);
   localparam int PW = (PRESC_W > 0) ? PRESC_W : 1;

   generate
      if (DW < timer_pkg::CB_DIV + PRESC_W) begin : g_bad_width
         $error("cpu_private_timer: DW too narrow for the prescale field");
      end
      if (PRESC_W > 8) begin : g_bad_presc
         $error("cpu_private_timer: prescale field limited to 8 bits");
      end
   endgenerate

   logic [DW-1:0] reload_w, cnt_w, cnt_set_val;
   logic          run_w, auto_w, unmask_w, flag_w;
   logic [PW-1:0] divide_w;
   logic          cnt_set, arm, arm_reload, halt, step, hit_zero;

   timer_regs #(.DW(DW), .PRESC_W(PRESC_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_sel     (bus_sel),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .count       (cnt_w),
      .hit_zero    (hit_zero),
      .reload_q    (reload_w),
      .run_q       (run_w),
      .auto_q      (auto_w),
      .unmask_q    (unmask_w),
      .divide_q    (divide_w),
      .flag_q      (flag_w),
      .cnt_set     (cnt_set),
      .cnt_set_val (cnt_set_val),
      .arm         (arm),
      .arm_reload  (arm_reload),
      .halt        (halt)
   );

   timer_prescale #(.PRESC_W(PRESC_W)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .run     (run_w),
      .restart (arm),
      .stop    (halt),
      .divide  (divide_w),
      .step    (step)
   );

   timer_counter #(.DW(DW)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .set        (cnt_set),
      .set_val    (cnt_set_val),
      .arm_reload (arm_reload),
      .reload_val (reload_w),
      .auto_rl    (auto_w),
      .step       (step),
      .count      (cnt_w),
      .hit_zero   (hit_zero)
   );

   assign irq = flag_w && unmask_w;
endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick_en,
   input logic          bus_sel,
   input logic          bus_wr,
   input logic [1:0]    bus_addr,
   input logic          irq,
   input logic [DW-1:0] cnt,
   input logic          flag,
   input logic          run,
   input logic          auto_rl,
   input logic          unmask
);
   logic wr;
   assign wr = bus_sel && bus_wr;

   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr) |=> $stable(cnt)); // R10

   AST_NO_TICK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !wr) |=> $stable(cnt)); // R12

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && cnt > DW'(1)) |=> (cnt == $past(cnt) || cnt == $past(cnt) - DW'(1))); // R3

   AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && run && !auto_rl && cnt == '0) |=> (cnt == '0)); // R4

   AST_FLAG_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> ($past(cnt) == DW'(1))); // R4

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(wr && bus_addr == 2'd3)) |=> flag); // R7

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag); // R6

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !unmask |-> !irq); // R6
endmodule

bind cpu_private_timer timer_chk #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .irq      (irq),
   .cnt      (cnt_w),
   .flag     (flag_w),
   .run      (run_w),
   .auto_rl  (auto_w),
   .unmask   (unmask_w)
);

// File: tb/sim_cpu_private_timer.sv
module sim_cpu_private_timer;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int WATCHDOG = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b1;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [1:0]    bus_addr = 2'd0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cpu_private_timer #(.DW(DW), .PRESC_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input string req, input string what,
                        input logic [DW-1:0] got, input logic [DW-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [DW-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_reg(input string req, input logic [1:0] a,
                             input logic [DW-1:0] exp);
      logic [DW-1:0] v;
      rd_reg(a, v);
      check(req, $sformatf("reg%0d", a), v, exp);
   endtask

   task automatic t_reset;
      for (int i = 0; i < 4; i++) expect_reg("R1", 2'(i), '0);
      check("R1", "irq", DW'(irq), '0);
   endtask

   task automatic t_regmap;
      wr_reg(2'd0, 5);
      expect_reg("R2", 2'd0, 5);
      expect_reg("R2", 2'd1, 5);
      wr_reg(2'd1, 7);
      expect_reg("R2", 2'd1, 7);
      expect_reg("R2", 2'd0, 5);
      wr_reg(2'd0, 5);
      expect_reg("R2", 2'd1, 5);
   endtask

   task automatic t_oneshot;
      wr_reg(2'd2, 32'h5);
      expect_reg("R9", 2'd1, 5);
      idle(3);
      expect_reg("R3", 2'd1, 2);
      idle(2);
      expect_reg("R4", 2'd1, 0);
      expect_reg("R4", 2'd3, 1);
      check("R6", "irq unmasked", DW'(irq), 1);
      idle(4);
      expect_reg("R4", 2'd1, 0);
   endtask

   task automatic t_status;
      wr_reg(2'd3, 32'h0);
      expect_reg("R7", 2'd3, 1);
      check("R7", "irq after zero write", DW'(irq), 1);
      wr_reg(2'd3, 32'h1);
      expect_reg("R7", 2'd3, 0);
      check("R7", "irq after clear", DW'(irq), 0);
   endtask

   task automatic t_autoreload;
      wr_reg(2'd2, 32'h0);
      wr_reg(2'd0, 3);
      wr_reg(2'd2, 32'h3);
      expect_reg("R9", 2'd1, 3);
      idle(2);
      expect_reg("R3", 2'd1, 1);
      idle(1);
      expect_reg("R5", 2'd1, 3);
      expect_reg("R5", 2'd3, 1);
      check("R6", "irq masked", DW'(irq), 0);
      idle(1);
      expect_reg("R5", 2'd1, 2);
   endtask

   task automatic t_leave_alone;
      wr_reg(2'd2, 32'h3);
      expect_reg("R8", 2'd1, 1);
   endtask

   task automatic t_rearm_at_zero;
      wr_reg(2'd2, 32'h0);
      wr_reg(2'd3, 32'h1);
      wr_reg(2'd0, 4);
      wr_reg(2'd2, 32'h1);
      idle(4);
      expect_reg("R4", 2'd1, 0);
      wr_reg(2'd2, 32'h3);
      expect_reg("R9", 2'd1, 4);
   endtask

   task automatic t_halt;
      idle(1);
      expect_reg("R3", 2'd1, 3);
      wr_reg(2'd2, 32'h2);
      expect_reg("R10", 2'd1, 3);
      idle(6);
      expect_reg("R10", 2'd1, 3);
   endtask

   task automatic t_restart_keep;
      wr_reg(2'd2, 32'h1);
      expect_reg("R9", 2'd1, 3);
      idle(2);
      expect_reg("R9", 2'd1, 1);
   endtask

   task automatic t_prescale;
      wr_reg(2'd2, 32'h0);
      wr_reg(2'd0, 10);
      wr_reg(2'd2, 32'h301);
      expect_reg("R2", 2'd2, 32'h301);
      idle(3);
      expect_reg("R11", 2'd1, 10);
      idle(1);
      expect_reg("R11", 2'd1, 9);
      idle(4);
      expect_reg("R11", 2'd1, 8);
   endtask

   task automatic t_tick_gate;
      tick_en = 1'b0;
      idle(10);
      expect_reg("R12", 2'd1, 8);
      tick_en = 1'b1;
      idle(4);
      expect_reg("R12", 2'd1, 7);
   endtask

   task automatic t_ctrl_bits;
      wr_reg(2'd2, 32'hFFFF_F0F8);
      expect_reg("R2", 2'd2, 32'h0000_F000);
      idle(3);
      expect_reg("R10", 2'd1, 7);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_oneshot();
      t_status();
      t_autoreload();
      t_leave_alone();
      t_rearm_at_zero();
      t_halt();
      t_restart_keep();
      t_prescale();
      t_tick_gate();
      t_ctrl_bits();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule